// File: doc/BRIEF.md
# Memory-Mapped Data Memory Decoder

This block is the data-memory side of a small 16-bit computer. A single 15-bit word address is split into three targets: a general-purpose RAM in the low half of the space, a screen buffer in the next quarter, and one read-only word that reflects the keyboard. Only the top address bits choose the target. The remaining low bits pass straight through as the word offset inside that target.

The write strobe reaches only the chosen storage bank, so the keyboard word and the unmapped addresses cannot be written. The read word is taken from whichever target the current address selects, with no added latency. Writes are captured on the rising clock edge.

Both storage arrays sit inside the block. The keyboard value arrives on an input port. Each bank holds 2^N physical words, addressed by the low N bits of its offset. Setting the bank-width parameters to 14 and 13 gives full-size banks. The defaults are smaller and alias the upper offset bits.

Top module: `memdec_top`

## Requirements
- R1: Addresses 0x0000 to 0x3FFF (address bit 14 = 0) select the RAM bank; the word used is address bits [RAM_AW-1:0].
- R2: Addresses 0x4000 to 0x5FFF (address bits [14:13] = 2'b10) select the screen bank; the word used is address bits [SCR_AW-1:0].
- R3: Address 0x6000 reads back the current value of kbd_code_i, combinationally.
- R4: A write to address 0x6000 changes no stored word in either bank, and the keyboard read still returns kbd_code_i.
- R5: Addresses 0x6001 to 0x7FFF read as 0x0000, and writes to them change no stored word.
- R6: With wr_en_i high at a rising clock edge, wdata_i is stored at the addressed word. The stored value is visible on rdata_o right after that edge, because reads follow the current address with no register stage.
- R7: With wr_en_i low, no stored word changes.
- R8: A write to one bank leaves the word at the same offset in the other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes land on its rising edge |
| addr_i | input | 15 | Word address |
| wdata_i | input | 16 | Data to write |
| wr_en_i | input | 1 | Write strobe |
| kbd_code_i | input | 16 | Current keyboard code, read at 0x6000 |
| rdata_o | output | 16 | Word read from the selected target |

## Verification
The bench aims at the region edges: 0x3FFF/0x4000, 0x5FFF/0x6000 and 0x6000/0x6001. At these points a decoder that tests the wrong bit would put a write into the wrong bank or return the wrong bank's data. Writes to the keyboard word and to the unmapped tail are followed by reads of both banks at the aliased offset. A demultiplexer that let the strobe through in those cases would show up as corrupted RAM or screen words. The bench also writes one bank and reads the other bank at the same offset, which catches shared write enables. A read taken in the cycle right after each write exposes any extra register stage on the read path.

// File: rtl/memdec_pkg.sv
package memdec_pkg;
    localparam int ADDR_W = 15;
    localparam int DATA_W = 16;
    localparam logic [ADDR_W-1:0] KBD_ADDR = 15'h6000;

    typedef enum logic [1:0] {
        TGT_RAM    = 2'd0,
        TGT_SCREEN = 2'd1,
        TGT_KBD    = 2'd2,
        TGT_NONE   = 2'd3
    } target_e;
endpackage

// File: rtl/memdec_region_decode.sv
module memdec_region_decode
    import memdec_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output target_e           target_o
);
    always_comb begin
        if (!addr_i[14])
            target_o = TGT_RAM;
        else if (!addr_i[13])
            target_o = TGT_SCREEN;
        else if (addr_i == KBD_ADDR)
            target_o = TGT_KBD;
        else
            target_o = TGT_NONE;
    end
endmodule

// File: rtl/memdec_bank.sv
module memdec_bank #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] idx_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i)
            cells[idx_i] <= wdata_i;
    end

    assign rdata_o = cells[idx_i];
endmodule

// File: rtl/memdec_top.sv
module memdec_top
    import memdec_pkg::*;
#(
    parameter int RAM_AW = 8,
    parameter int SCR_AW = 7
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] kbd_code_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int NBANK = 2;
    localparam int BANK_AW [NBANK] = '{RAM_AW, SCR_AW};

    target_e           target;
    logic [NBANK-1:0]  bank_we;
    logic [DATA_W-1:0] bank_rd [NBANK];

    memdec_region_decode u_dec (
        .addr_i   (addr_i),
        .target_o (target)
    );

    // write demultiplexer: only storage targets receive the strobe
    always_comb begin
        bank_we = '0;
        unique case (target)
            TGT_RAM:    bank_we[0] = wr_en_i;
            TGT_SCREEN: bank_we[1] = wr_en_i;
            TGT_KBD, TGT_NONE: bank_we = '0;
        endcase
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        memdec_bank #(
            .AW (BANK_AW[b]),
            .DW (DATA_W)
        ) u_bank (
            .clk     (clk),
            .we_i    (bank_we[b]),
            .idx_i   (addr_i[BANK_AW[b]-1:0]),
            .wdata_i (wdata_i),
            .rdata_o (bank_rd[b])
        );
    end

    // read multiplexer
    always_comb begin
        unique case (target)
            TGT_RAM:    rdata_o = bank_rd[0];
            TGT_SCREEN: rdata_o = bank_rd[1];
            TGT_KBD:    rdata_o = kbd_code_i;
            TGT_NONE:   rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/memdec_chk.sv
module memdec_chk
    import memdec_pkg::*;
(
    input logic              clk,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic              wr_en_i,
    input logic [DATA_W-1:0] kbd_code_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic [1:0]        bank_we
);
    logic started = 1'b0;
    always_ff @(posedge clk) started <= 1'b1;

    // R1
    ram_strobe_chk: assert property (@(posedge clk) disable iff (!started)
        (wr_en_i && addr_i < 15'h4000) |-> (bank_we == 2'b01));

    // R2
    scr_strobe_chk: assert property (@(posedge clk) disable iff (!started)
        (wr_en_i && addr_i >= 15'h4000 && addr_i < 15'h6000) |-> (bank_we == 2'b10));

    // R3
    kbd_read_chk: assert property (@(posedge clk) disable iff (!started)
        (addr_i == 15'h6000) |-> (rdata_o == kbd_code_i));

    // R4
    kbd_nowrite_chk: assert property (@(posedge clk) disable iff (!started)
        (addr_i >= 15'h6000) |-> (bank_we == 2'b00));

    // R5
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!started)
        (addr_i > 15'h6000) |-> (rdata_o == '0));

    // R7
    idle_strobe_chk: assert property (@(posedge clk) disable iff (!started)
        !wr_en_i |-> (bank_we == 2'b00));

    // R6
    ram_readback_chk: assert property (@(posedge clk) disable iff (!started)
        (wr_en_i && addr_i < 15'h6000) |=>
            ((addr_i != $past(addr_i)) || (rdata_o == $past(wdata_i))));
endmodule

bind memdec_top memdec_chk u_chk (
    .clk        (clk),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .wr_en_i    (wr_en_i),
    .kbd_code_i (kbd_code_i),
    .rdata_o    (rdata_o),
    .bank_we    (bank_we)
);

// File: tb/memdec_top_bench.sv
module memdec_top_bench;
    localparam int RAM_AW = 8;
    localparam int SCR_AW = 7;
    localparam int RAM_N  = 1 << RAM_AW;
    localparam int SCR_N  = 1 << SCR_AW;

    logic        clk = 1'b0;
    logic [14:0] addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic        wr_en_i = 1'b0;
    logic [15:0] kbd_code_i = '0;
    logic [15:0] rdata_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] ram_m [RAM_N];
    logic [15:0] scr_m [SCR_N];

    always #4 clk = ~clk;

    memdec_top #(.RAM_AW(RAM_AW), .SCR_AW(SCR_AW)) u_memdec_top (
        .clk        (clk),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .wr_en_i    (wr_en_i),
        .kbd_code_i (kbd_code_i),
        .rdata_o    (rdata_o)
    );

    function automatic logic [15:0] exp_read(input logic [14:0] a);
        if (a < 15'h4000)      return ram_m[a[RAM_AW-1:0]];
        else if (a < 15'h6000) return scr_m[a[SCR_AW-1:0]];
        else if (a == 15'h6000) return kbd_code_i;
        else                   return 16'h0000;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic write_op(input logic [14:0] a, input logic [15:0] d, input logic we);
        @(negedge clk);
        addr_i = a; wdata_i = d; wr_en_i = we;
        @(posedge clk);
        if (we) begin
            if (a < 15'h4000)      ram_m[a[RAM_AW-1:0]] = d;
            else if (a < 15'h6000) scr_m[a[SCR_AW-1:0]] = d;
        end
        #1;
    endtask

    task automatic read_chk(input logic [14:0] a, input string req);
        @(negedge clk);
        addr_i = a; wr_en_i = 1'b0;
        #1;
        check(req, rdata_o, exp_read(a));
    endtask

    initial begin
        int unused = $urandom(32'h5eed);
        for (int i = 0; i < RAM_N; i++) write_op(15'(i), 16'(i * 3 + 1), 1'b1);
        for (int i = 0; i < SCR_N; i++) write_op(15'h4000 + 15'(i), 16'hA000 + 16'(i), 1'b1);

        // R1 / R2 boundaries
        read_chk(15'h0000, "R1");
        read_chk(15'h3FFF, "R1");
        read_chk(15'h4000, "R2");
        read_chk(15'h5FFF, "R2");
        // R3
        kbd_code_i = 16'hBEEF;
        read_chk(15'h6000, "R3");
        kbd_code_i = 16'h0041;
        read_chk(15'h6000, "R3");
        // R4
        write_op(15'h6000, 16'hDEAD, 1'b1);
        check("R4", rdata_o, 16'h0041);
        read_chk(15'h0000, "R4");
        read_chk(15'h4000, "R4");
        // R5
        read_chk(15'h6001, "R5");
        read_chk(15'h7FFF, "R5");
        write_op(15'h7FFF, 16'h1234, 1'b1);
        check("R5", rdata_o, 16'h0000);
        read_chk(15'h7FFF & 15'(RAM_N - 1), "R5");
        read_chk(15'h4000 | (15'h7FFF & 15'(SCR_N - 1)), "R5");
        // R6: value visible right after the edge
        write_op(15'h0005, 16'hC0DE, 1'b1);
        check("R6", rdata_o, 16'hC0DE);
        write_op(15'h4005, 16'hFACE, 1'b1);
        check("R6", rdata_o, 16'hFACE);
        // R7
        write_op(15'h0005, 16'h9999, 1'b0);
        check("R7", rdata_o, 16'hC0DE);
        // R8
        write_op(15'h0007, 16'h7777, 1'b1);
        read_chk(15'h4007, "R8");
        write_op(15'h4009, 16'h8888, 1'b1);
        read_chk(15'h0009, "R8");

        for (int n = 0; n < 3000; n++) begin
            logic [14:0] a;
            int sel = $urandom_range(0, 9);
            if (sel < 4)       a = 15'($urandom_range(0, 16'h3FFF));
            else if (sel < 7)  a = 15'h4000 + 15'($urandom_range(0, 16'h1FFF));
            else if (sel < 8)  a = 15'h6000;
            else               a = 15'($urandom_range(16'h6001, 16'h7FFF));
            kbd_code_i = 16'($urandom);
            read_chk(a, "R1 R2 R3 R5 random read");
            write_op(a, 16'($urandom), 1'($urandom_range(0, 1)));
            check("R6 R7 random post-write", rdata_o, exp_read(a));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule